// File: doc/BRIEF.md
# Infrared carrier waveform generator

This block produces the modulated carrier for an infrared remote-control transmitter. The carrier alternates between a high phase and a low phase. Each phase has its own 8-bit length register, so the duty cycle can be asymmetric and is fully programmable. A two-bit clock-select field sets the rate of the counting clock to the system clock, half the system clock or twice the system clock. A separate enable bit turns the output on and off.

The block is clocked by the doubled system clock, which is supplied from outside. The system-clock and half-system-clock choices are made as count enables from a small prescaler, so the whole block runs in a single clock domain. Software programs the block through a plain write port with three registers. The output is a single push-pull level that goes to the emitter driver. Framing of the carrier into protocol bursts is done elsewhere.

Top module: `ircar_gen`

## Requirements
- R1: After reset the output is low, both length registers hold 0 and the control register holds 0 (disabled, select code 00).
- R2: Write address 0 sets the low-phase length L and address 1 sets the high-phase length H, both 8 bits. Address 2 is control: bit 1 is the enable and bits [3:2] are the clock select. The select codes are 00 = half rate (one count every 4 block-clock cycles), 01 = system rate (every 2 cycles), 10 = double rate (every cycle) and 11 = half rate.
- R3: While the enable is 0 the output is low and stays low, whatever is written to the length registers.
- R4: A control write with the enable set drives the output high from the clock edge that takes the write, so the high phase comes first.
- R5: With D counting-clock divisor cycles per count (4, 2 or 1), the high phase lasts (H+1)*D block-clock cycles and the low phase lasts (L+1)*D, repeating.
- R6: A length write takes effect at the next phase boundary and never shortens or extends the running phase. A write taken on the same edge as a boundary applies from the boundary after that one.
- R7: Any control write restarts the prescaler and the phase counter and puts the output in the high phase, including a write made during a low phase.
- R8: The extreme lengths 0 and 255 give phases of 1*D and 256*D cycles.
- R9: A write to address 3 changes neither the registers nor the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the system clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| carrier_out | output | 1 | Carrier output level |

## Verification
A length-register write can land on the same edge as a phase boundary, where the counter reloads its limit from that same register. The bench places the write exactly on the edge that ends the first high phase. It then checks that the low phase that follows still has the old width and that the new width appears one phase later. A control write can also meet a pending count tick or a boundary. The bench restarts the carrier part-way through both a high and a low phase and judges the measured run widths against lengths computed from the restart edge.

// File: rtl/ircar_pkg.sv
package ircar_pkg;

  typedef enum logic [1:0] {
    SEL_HALF   = 2'b00,
    SEL_FULL   = 2'b01,
    SEL_DOUBLE = 2'b10,
    SEL_SPARE  = 2'b11
  } csel_e;

  localparam int ADR_LOW      = 0;
  localparam int ADR_HIGH     = 1;
  localparam int ADR_CTRL     = 2;
  localparam int CTRL_EN_BIT  = 1;
  localparam int CTRL_SEL_LSB = 2;
  localparam int PRE_W        = 2;

  // prescaler bits that must all be one for a count tick
  function automatic logic [PRE_W-1:0] tick_mask(csel_e s);
    case (s)
      SEL_DOUBLE: tick_mask = 2'b00;
      SEL_FULL:   tick_mask = 2'b01;
      default:    tick_mask = 2'b11;
    endcase
  endfunction

  function automatic int unsigned tick_div(csel_e s);
    return 32'd1 << $countones(tick_mask(s));
  endfunction

endpackage

// File: rtl/ircar_regs.sv
module ircar_regs
  import ircar_pkg::*;
#(
  parameter int PER_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PER_W-1:0]  wr_data,
  output logic [PER_W-1:0]  lo_val,
  output logic [PER_W-1:0]  hi_val,
  output logic              enable,
  output csel_e             sel,
  output logic              ctrl_wr
);

  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(ADR_LOW);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(ADR_HIGH);
  localparam logic [ADDR_W-1:0] A_CT = ADDR_W'(ADR_CTRL);

  logic lo_wr, hi_wr;
  assign lo_wr   = wr_en && (wr_addr == A_LO);
  assign hi_wr   = wr_en && (wr_addr == A_HI);
  assign ctrl_wr = wr_en && (wr_addr == A_CT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_val <= '0;
      hi_val <= '0;
      enable <= 1'b0;
      sel    <= SEL_HALF;
    end else begin
      if (lo_wr) lo_val <= wr_data;
      if (hi_wr) hi_val <= wr_data;
      if (ctrl_wr) begin
        enable <= wr_data[CTRL_EN_BIT];
        sel    <= csel_e'(wr_data[CTRL_SEL_LSB +: 2]);
      end
    end
  end

  // R9: addresses past the control register touch nothing
  a_r9_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr > A_CT)) |=>
      ($stable(lo_val) && $stable(hi_val) && $stable(enable) && $stable(sel)));

endmodule

// File: rtl/ircar_prescale.sv
module ircar_prescale
  import ircar_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold,
  input  csel_e sel,
  output logic  tick
);

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;

  assign mask = tick_mask(sel);
  assign tick = !hold && ((pre & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre <= '0;
    else if (hold) pre <= '0;
    else           pre <= pre + 1'b1;
  end

  // R5: at system rate two ticks are never adjacent
  a_r5_full_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel == SEL_FULL && $stable(sel)) |=> !tick);

  // R5: at half rate a tick is followed by at least one quiet cycle
  a_r5_half_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (sel == SEL_HALF || sel == SEL_SPARE)) |=> !tick);

endmodule

// File: rtl/ircar_phase.sv
module ircar_phase
  import ircar_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart,
  input  logic             tick,
  input  logic [PER_W-1:0] lo_val,
  input  logic [PER_W-1:0] hi_val,
  output logic             phase_hi,
  output logic             boundary
);

  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] cur_len;

  assign boundary = enable && !restart && tick && (cnt == cur_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cur_len  <= '0;
      phase_hi <= 1'b1;
    end else if (restart || !enable) begin
      cnt      <= '0;
      cur_len  <= hi_val;
      phase_hi <= 1'b1;
    end else if (boundary) begin
      cnt      <= '0;
      cur_len  <= phase_hi ? lo_val : hi_val;
      phase_hi <= !phase_hi;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: the limit of a running phase never changes
  a_r6_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !restart && !boundary) |=> $stable(cur_len));

  // R5: the counter never passes the phase limit
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (cnt <= cur_len));

  // R5: the phase only flips on a count tick
  a_r5_flip_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !restart && !tick) |=> $stable(phase_hi));

endmodule

// File: rtl/ircar_gen.sv
module ircar_gen
  import ircar_pkg::*;
#(
  parameter int PER_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PER_W-1:0]  wr_data,
  output logic              carrier_out
);

  logic [PER_W-1:0] lo_val, hi_val;
  logic             enable, ctrl_wr, tick, phase_hi, boundary, pre_hold;
  csel_e            sel;

  ircar_regs #(.PER_W(PER_W), .ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .lo_val, .hi_val, .enable, .sel, .ctrl_wr
  );

  assign pre_hold = ctrl_wr || !enable;

  ircar_prescale u_pre (
    .clk, .rst_n, .hold(pre_hold), .sel, .tick
  );

  ircar_phase #(.PER_W(PER_W)) u_phase (
    .clk, .rst_n, .enable, .restart(ctrl_wr), .tick,
    .lo_val, .hi_val, .phase_hi, .boundary
  );

  assign carrier_out = enable && phase_hi;

  // R3: a control write clearing the enable silences the output
  a_r3_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(ADR_CTRL) && !wr_data[CTRL_EN_BIT]) |=> !carrier_out);

  // R4 / R7: a control write with the enable set starts in the high phase
  a_r7_restart_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(ADR_CTRL) && wr_data[CTRL_EN_BIT]) |=> carrier_out);

  // R5: every phase boundary shows as a level change on the pin
  a_r5_boundary_edge: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (carrier_out != $past(carrier_out)));

  // R3: without enable the output stays low
  a_r3_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!carrier_out && !(wr_en && wr_addr == ADDR_W'(ADR_CTRL))) |=>
      (!carrier_out || $past(enable)));

endmodule

// File: tb/ircar_gen_bench.sv
module ircar_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       carrier_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int   widths[$];
  logic mon_last = 1'b0;
  int   mon_len = 0;

  ircar_gen u_ircar_gen (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .carrier_out
  );

  always #4 clk = ~clk;

  // run-length monitor, sampling 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (carrier_out === mon_last) mon_len++;
    else begin
      widths.push_back(mon_len);
      mon_last = carrier_out;
      mon_len  = 1;
    end
  end

  function automatic int exp_w(int v, int sel);
    int div;
    if (sel == 2)      div = 1;
    else if (sel == 1) div = 2;
    else               div = 4;
    return (v + 1) * div;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(int a, int d);
    wr_en   = 1'b1;
    wr_addr = 2'(a);
    wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic mon_clear();
    widths.delete();
    mon_last = carrier_out;
    mon_len  = 1;
  endtask

  task automatic wait_runs(int n);
    int g = 0;
    while (widths.size() < n && g < 6000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic chk_run(string req, int idx, int expv);
    int act = (widths.size() > idx) ? widths[idx] : -1;
    chk(act == expv, req, act, expv);
  endtask

  task automatic run_check(string req, int sel, int h, int l);
    wr(0, l);
    wr(1, h);
    wr(2, (sel << 2) | 2);
    mon_clear();
    wait_runs(3);
    chk_run(req, 0, exp_w(h, sel));
    chk_run(req, 1, exp_w(l, sel));
    chk_run(req, 2, exp_w(h, sel));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, then enable only gives 4-cycle phases of length 0
    chk(carrier_out == 1'b0, "R1 reset low", int'(carrier_out), 0);
    wr(2, 2);
    mon_clear();
    chk(carrier_out == 1'b1, "R4 high first", int'(carrier_out), 1);
    wait_runs(3);
    chk_run("R1 reset lengths", 0, 4);
    chk_run("R1 reset lengths", 1, 4);

    // R5 / R2: each select code with directed lengths
    run_check("R5 double", 2, 3, 7);
    run_check("R5 system", 1, 5, 2);
    run_check("R5 half", 0, 2, 4);
    run_check("R2 code11 half", 3, 1, 3);

    // R8: extremes
    run_check("R8 max high", 0, 255, 0);
    run_check("R8 max low", 2, 0, 255);

    // R5: random lengths and selects
    for (int i = 0; i < 8; i++) begin
      int s = $urandom_range(2);
      int h = $urandom_range(40);
      int l = $urandom_range(40);
      run_check("R5 random", s, h, l);
    end

    // R6: mid-phase write does not shorten the running phase
    wr(0, 5);
    wr(1, 20);
    wr(2, (2 << 2) | 2);
    mon_clear();
    repeat (4) @(negedge clk);
    wr(1, 3);
    wait_runs(4);
    chk_run("R6 mid write", 0, 21);
    chk_run("R6 mid write", 1, 6);
    chk_run("R6 mid write", 2, 4);

    // R6: write taken on the boundary edge applies one phase later
    wr(0, 5);
    wr(1, 5);
    wr(2, (2 << 2) | 2);
    mon_clear();
    repeat (5) @(negedge clk);
    wr(0, 2);
    wait_runs(4);
    chk_run("R6 boundary write", 0, 6);
    chk_run("R6 boundary write", 1, 6);
    chk_run("R6 boundary write", 2, 6);
    chk_run("R6 boundary write", 3, 3);

    // R7: select change mid high phase restarts the count
    wr(0, 9);
    wr(1, 9);
    wr(2, (2 << 2) | 2);
    mon_clear();
    repeat (3) @(negedge clk);
    wr(2, (1 << 2) | 2);
    wait_runs(2);
    chk_run("R7 restart high", 0, 24);
    chk_run("R7 restart high", 1, 20);

    // R7: control write in a low phase returns high at once
    wr(0, 30);
    wr(1, 1);
    wr(2, (2 << 2) | 2);
    repeat (4) @(negedge clk);
    chk(carrier_out == 1'b0, "R7 in low phase", int'(carrier_out), 0);
    wr(2, (2 << 2) | 2);
    chk(carrier_out == 1'b1, "R7 restart from low", int'(carrier_out), 1);

    // R9: unused address leaves the waveform alone
    wr(0, 2);
    wr(1, 2);
    wr(2, (2 << 2) | 2);
    mon_clear();
    wr(3, 8'hff);
    wait_runs(4);
    chk_run("R9 unused addr", 0, 3);
    chk_run("R9 unused addr", 1, 3);
    chk_run("R9 unused addr", 2, 3);
    chk_run("R9 unused addr", 3, 3);

    // R3: disable drives low and holds it through length writes
    wr(2, 0);
    chk(carrier_out == 1'b0, "R3 disable low", int'(carrier_out), 0);
    mon_clear();
    wr(0, 1);
    wr(1, 0);
    repeat (40) @(negedge clk);
    chk(widths.size() == 0, "R3 no toggles", widths.size(), 0);
    chk(carrier_out == 1'b0, "R3 still low", int'(carrier_out), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule